// File: doc/BRIEF.md
# Block Hamming ECC Engine

This engine watches the byte stream that flows between a memory controller and a NAND device and computes a single-error-correct, double-error-detect Hamming code over each 512-byte block. A block begins on its own when an accepted byte sits at a 512-byte-aligned address while the engine is idle. From then on it takes up to 512 bytes. A byte flagged as last closes the block early.

On a write block the engine presents the 24-bit code, which the controller stores in the page spare area behind the data. On a read block the engine waits for the stored code of that block. It XORs the stored code with the computed one and reports one of four results: clean, a correctable single-bit error with its byte and bit location, an error in the stored code itself, or an uncorrectable error. The result stays on the outputs until software acknowledges it. The engine does not correct the data.

The input is a valid/ready stream. A byte moves when `s_valid` and `s_ready` are both high on a rising clock edge. `s_ready` stays high while the engine is idle or inside a block. It drops while the engine waits for a stored code, and while a result is held. A source therefore cannot start the next block before the previous result is acknowledged.

Top module: `nand_blk_ecc`

## Requirements
- R1: After reset, `s_ready` is 1 and `res_valid` is 0.
- R2: While idle, an accepted byte whose address offset is not 0 is ignored. No block starts, no result appears, and the bytes leave no trace in the next block's code.
- R3: Byte i of a block (i = 0..511) with parity p enters the code as follows. Bit k (k = 0..8) is the XOR of p over bytes whose index has bit k clear. Bit 9+k is the same XOR over bytes whose index has bit k set. Bit 18+j (j = 0..2) is the XOR of every data bit n with bit j of n clear. Bit 21+j is the same XOR over data bits with bit j of n set. After the 512th byte of a write block, `res_valid` rises with `res_is_read`=0 and this code on `res_code`. All status flags are 0.
- R4: An accepted byte with `s_last`=1 closes the block after that byte, whatever its length. The code then covers only the bytes taken.
- R5: While waiting for a stored code or holding a result, `s_ready` is 0. A held result and its code do not change until `res_ack` is sampled high, after which `res_valid` falls.
- R6: On a read, the stored code is taken when `stored_valid` is high. A zero syndrome (stored XOR computed) gives `st_clean`=1. Exactly one status flag is set for every read result.
- R7: A syndrome that has exactly one bit set in each of the 12 pairs (k, 9+k) and (18+j, 21+j) gives `st_fixable`=1. `fix_byte` then equals syndrome bits [17:9] and `fix_bit` equals bits [23:21]. This is the location of a single flipped data bit.
- R8: A syndrome with exactly one bit set gives `st_code_err`=1.
- R9: Any other non-zero syndrome gives `st_uncorr`=1.
- R10: `fix_byte` and `fix_bit` are 0 whenever `st_fixable` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Stream byte valid |
| s_ready | output | 1 | Engine can take a byte |
| s_data | input | 8 | Stream byte |
| s_addr_ofs | input | 9 | Address of the byte within a 512-byte block |
| s_write | input | 1 | 1 = write access, 0 = read (sampled on the block's first byte) |
| s_last | input | 1 | Close the block after this byte |
| stored_valid | input | 1 | Stored code present (read blocks) |
| stored_code | input | 24 | Code read from the spare area |
| res_ack | input | 1 | Software has taken the result |
| res_valid | output | 1 | Result held |
| res_is_read | output | 1 | Result belongs to a read block |
| res_code | output | 24 | Computed code of the block |
| st_clean | output | 1 | Read: no error |
| st_fixable | output | 1 | Read: single correctable data error |
| st_code_err | output | 1 | Read: error within the stored code |
| st_uncorr | output | 1 | Read: uncorrectable error |
| fix_byte | output | 9 | Byte index of the correctable error |
| fix_bit | output | 3 | Bit index of the correctable error |

## Verification
A wrong byte counter or a wrong start rule shows up as a code that covers the wrong set of bytes. It also shows up as a result arriving earlier or later than the block length implies, and the mismatch is visible on the very first result. A fault in any one parity lane corrupts a single bit of `res_code` on most data patterns. Pairing faults in the syndrome decoder misreport the status or the location. These appear once a flipped bit is swept through every byte-index bit and every bit position, with each stored-code bit flipped as well.

// File: rtl/nand_blk_ecc_pkg.sv
package nand_blk_ecc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_WCODE = 2'd2,
    ST_HOLD  = 2'd3
  } ecc_state_e;
endpackage

// File: rtl/nand_blk_ecc_accum.sv
module nand_blk_ecc_accum #(
  parameter int IDX_W  = 9,
  parameter int CODE_W = 2 * IDX_W + 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              first,
  input  logic [IDX_W-1:0]  idx,
  input  logic [7:0]        data,
  output logic [CODE_W-1:0] code
);
  localparam int COL0 = 2 * IDX_W;

  logic              byte_par;
  logic [CODE_W-1:0] contrib;

  assign byte_par = ^data;

  always_comb begin
    contrib = '0;
    for (int k = 0; k < IDX_W; k++) begin
      if (idx[k]) contrib[IDX_W + k] = byte_par;
      else        contrib[k]         = byte_par;
    end
    for (int j = 0; j < 3; j++) begin
      for (int n = 0; n < 8; n++) begin
        if (((n >> j) & 1) == 1) contrib[COL0 + 3 + j] = contrib[COL0 + 3 + j] ^ data[n];
        else                     contrib[COL0 + j]     = contrib[COL0 + j] ^ data[n];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   code <= '0;
    else if (en)  code <= first ? contrib : (code ^ contrib);
  end
endmodule

// File: rtl/nand_blk_ecc_classify.sv
module nand_blk_ecc_classify #(
  parameter int IDX_W  = 9,
  parameter int CODE_W = 2 * IDX_W + 6
) (
  input  logic [CODE_W-1:0] syn,
  input  logic              enable,
  output logic              clean,
  output logic              fixable,
  output logic              code_err,
  output logic              uncorr,
  output logic [IDX_W-1:0]  loc_byte,
  output logic [2:0]        loc_bit
);
  localparam int COL0 = 2 * IDX_W;

  logic [IDX_W-1:0] row_lo, row_hi;
  logic [2:0]       col_lo, col_hi;
  logic             pairs_ok, is_zero, is_single;

  assign row_lo    = syn[IDX_W-1:0];
  assign row_hi    = syn[COL0-1:IDX_W];
  assign col_lo    = syn[COL0+2:COL0];
  assign col_hi    = syn[COL0+5:COL0+3];
  assign pairs_ok  = (&(row_lo ^ row_hi)) && (&(col_lo ^ col_hi));
  assign is_zero   = (syn == '0);
  assign is_single = $onehot(syn);

  assign clean    = enable && is_zero;
  assign fixable  = enable && pairs_ok;
  assign code_err = enable && is_single;
  assign uncorr   = enable && !is_zero && !pairs_ok && !is_single;
  assign loc_byte = fixable ? row_hi : '0;
  assign loc_bit  = fixable ? col_hi : '0;
endmodule

// File: rtl/nand_blk_ecc.sv
module nand_blk_ecc
  import nand_blk_ecc_pkg::*;
#(
  parameter int BLK_BYTES = 512,
  parameter int IDX_W     = $clog2(BLK_BYTES),
  parameter int CODE_W    = 2 * IDX_W + 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [7:0]        s_data,
  input  logic [IDX_W-1:0]  s_addr_ofs,
  input  logic              s_write,
  input  logic              s_last,
  input  logic              stored_valid,
  input  logic [CODE_W-1:0] stored_code,
  input  logic              res_ack,
  output logic              res_valid,
  output logic              res_is_read,
  output logic [CODE_W-1:0] res_code,
  output logic              st_clean,
  output logic              st_fixable,
  output logic              st_code_err,
  output logic              st_uncorr,
  output logic [IDX_W-1:0]  fix_byte,
  output logic [2:0]        fix_bit
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BLK_BYTES - 1);

  ecc_state_e        st;
  logic [IDX_W-1:0]  cnt;
  logic              is_rd;
  logic [CODE_W-1:0] syn;
  logic              accept, start, run_acc, closing, dir_rd;
  logic [CODE_W-1:0] acc_code;

  assign s_ready = (st == ST_IDLE) || (st == ST_RUN);
  assign accept  = s_valid && s_ready;
  assign start   = (st == ST_IDLE) && accept && (s_addr_ofs == '0);
  assign run_acc = (st == ST_RUN) && accept;
  assign closing = (start && s_last) || (run_acc && (s_last || cnt == LAST_IDX));
  assign dir_rd  = start ? !s_write : is_rd;

  nand_blk_ecc_accum #(.IDX_W(IDX_W), .CODE_W(CODE_W)) u_accum (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (start || run_acc),
    .first (start),
    .idx   (start ? '0 : cnt),
    .data  (s_data),
    .code  (acc_code)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      cnt   <= '0;
      is_rd <= 1'b0;
      syn   <= '0;
    end else begin
      if (start) begin
        cnt   <= IDX_W'(1);
        is_rd <= !s_write;
      end else if (run_acc) begin
        cnt <= cnt + 1'b1;
      end
      case (st)
        ST_IDLE, ST_RUN: begin
          if (closing)    st <= dir_rd ? ST_WCODE : ST_HOLD;
          else if (start) st <= ST_RUN;
        end
        ST_WCODE: if (stored_valid) begin
          syn <= stored_code ^ acc_code;
          st  <= ST_HOLD;
        end
        ST_HOLD: if (res_ack) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign res_valid   = (st == ST_HOLD);
  assign res_is_read = is_rd;
  assign res_code    = acc_code;

  nand_blk_ecc_classify #(.IDX_W(IDX_W), .CODE_W(CODE_W)) u_classify (
    .syn      (syn),
    .enable   (res_valid && is_rd),
    .clean    (st_clean),
    .fixable  (st_fixable),
    .code_err (st_code_err),
    .uncorr   (st_uncorr),
    .loc_byte (fix_byte),
    .loc_bit  (fix_bit)
  );

  assert_stall_while_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WCODE || res_valid) |-> !s_ready);
  assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ack) |=> (res_valid && $stable(res_code) && $stable(fix_byte)));
  assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ack) |=> !res_valid);
  assert_one_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_is_read) |-> $onehot({st_clean, st_fixable, st_code_err, st_uncorr}));
  assert_write_no_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!res_valid || !res_is_read) |-> ({st_clean, st_fixable, st_code_err, st_uncorr} == 4'b0));
  assert_loc_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !st_fixable |-> (fix_byte == '0 && fix_bit == '0));
  assert_cnt_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN) |-> (cnt != '0));
endmodule

// File: tb/nand_blk_ecc_tb.sv
module nand_blk_ecc_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0, s_write = 1'b0, s_last = 1'b0;
  logic [7:0]  s_data = '0;
  logic [8:0]  s_addr_ofs = '0;
  logic        stored_valid = 1'b0, res_ack = 1'b0;
  logic [23:0] stored_code = '0;
  logic        s_ready, res_valid, res_is_read;
  logic [23:0] res_code;
  logic        st_clean, st_fixable, st_code_err, st_uncorr;
  logic [8:0]  fix_byte;
  logic [2:0]  fix_bit;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] mem [512];

  always #2.5 clk = ~clk;

  nand_blk_ecc u_dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] calc(input int len);
    logic [23:0] c = '0;
    for (int i = 0; i < len; i++) begin
      logic p = ^mem[i];
      for (int k = 0; k < 9; k++)
        if (((i >> k) & 1) == 1) c[9 + k] ^= p; else c[k] ^= p;
      for (int j = 0; j < 3; j++)
        for (int n = 0; n < 8; n++)
          if (((n >> j) & 1) == 1) c[21 + j] ^= mem[i][n]; else c[18 + j] ^= mem[i][n];
    end
    return c;
  endfunction

  function automatic logic [23:0] loc_syn(input int b, input int j);
    logic [23:0] s = '0;
    for (int k = 0; k < 9; k++) s[((b >> k) & 1) == 1 ? 9 + k : k] = 1'b1;
    for (int q = 0; q < 3; q++) s[((j >> q) & 1) == 1 ? 21 + q : 18 + q] = 1'b1;
    return s;
  endfunction

  task automatic send(input int len, input bit wr, input bit use_last, input int fi, input int fb);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      s_valid = 1'b1; s_write = wr; s_addr_ofs = 9'(k);
      s_data = mem[k] ^ ((k == fi) ? 8'(1 << fb) : 8'h00);
      s_last = use_last && (k == len - 1);
    end
    @(negedge clk);
    s_valid = 1'b0; s_last = 1'b0;
  endtask

  task automatic give(input logic [23:0] c);
    chk(s_ready == 1'b0 && res_valid == 1'b0, "R5 stall awaiting code", {s_ready, res_valid}, 0);
    stored_valid = 1'b1; stored_code = c;
    @(negedge clk);
    stored_valid = 1'b0;
  endtask

  task automatic ack();
    res_ack = 1'b1;
    @(negedge clk);
    res_ack = 1'b0;
    chk(res_valid == 1'b0, "R5 released", res_valid, 0);
  endtask

  task automatic wr_check(input int len, input bit use_last, input string req);
    logic [23:0] e;
    e = calc(len);
    send(len, 1'b1, use_last, -1, 0);
    chk(res_valid && !res_is_read && res_code == e, req, res_code, e);
    chk({st_clean, st_fixable, st_code_err, st_uncorr} == 0, "R3 write flags", 0, 0);
    ack();
  endtask

  task automatic rd_check(input int len, input int fi, input int fb, input logic [23:0] stored,
                          input logic [3:0] exp_st, input int eb, input int ebit, input string req);
    send(len, 1'b0, len < 512, fi, fb);
    give(stored);
    chk(res_valid && res_is_read && {st_clean, st_fixable, st_code_err, st_uncorr} == exp_st,
        req, {st_clean, st_fixable, st_code_err, st_uncorr}, exp_st);
    chk(fix_byte == 9'(eb) && fix_bit == 3'(ebit), "R10 location", {fix_byte, fix_bit}, {9'(eb), 3'(ebit)});
    ack();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = 8'(i * 37 + 5);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(s_ready == 1'b1 && res_valid == 1'b0, "R1 reset state", {s_ready, res_valid}, 2'b10);

    // R2: unaligned bytes in idle are ignored
    for (int k = 5; k < 12; k++) begin
      s_valid = 1'b1; s_write = 1'b1; s_addr_ofs = 9'(k); s_data = 8'hA5; s_last = (k == 11);
      @(negedge clk);
    end
    s_valid = 1'b0; s_last = 1'b0;
    repeat (2) @(negedge clk);
    chk(res_valid == 1'b0 && s_ready == 1'b1, "R2 no start off-alignment", {res_valid, s_ready}, 2'b01);
    wr_check(512, 1'b0, "R2 R3 code after ignored bytes");

    // R5: held result stays put without ack
    send(512, 1'b1, 1'b0, -1, 0);
    repeat (4) @(negedge clk);
    chk(res_valid && !s_ready && res_code == calc(512), "R5 hold stable", res_code, calc(512));
    ack();

    // R3: several data patterns
    for (int pat = 0; pat < 3; pat++) begin
      for (int i = 0; i < 512; i++)
        mem[i] = (pat == 0) ? 8'hFF : (pat == 1) ? 8'(i) : 8'((i * i * 13 + i * 7 + pat) >> 1);
      wr_check(512, 1'b0, "R3 full block code");
    end

    // R4: short blocks closed by last
    wr_check(1, 1'b1, "R4 len 1");
    wr_check(2, 1'b1, "R4 len 2");
    wr_check(7, 1'b1, "R4 len 7");
    wr_check(100, 1'b1, "R4 len 100");
    wr_check(511, 1'b1, "R4 len 511");
    wr_check(512, 1'b1, "R4 len 512 with last");

    // R6: clean reads
    rd_check(512, -1, 0, calc(512), 4'b1000, 0, 0, "R6 clean full");
    rd_check(9, -1, 0, calc(9), 4'b1000, 0, 0, "R6 clean short");

    // R7: single data-bit flips swept over byte-index bits and bit positions
    for (int bi = 0; bi < 12; bi++) begin
      int b;
      b = (bi < 10) ? ((bi == 0) ? 0 : (1 << (bi - 1))) : ((bi == 10) ? 511 : 300);
      for (int j = 0; j < 8; j++)
        rd_check(512, b, j, calc(512), 4'b0100, b, j, "R7 single-bit fix");
    end
    for (int b = 0; b < 16; b++)
      rd_check(16, -1, 0, calc(16) ^ loc_syn(b * 31, b % 8), 4'b0100, b * 31, b % 8, "R7 syndrome location");

    // R8: single flipped bit in the stored code
    for (int n = 0; n < 24; n++)
      rd_check(3, -1, 0, calc(3) ^ (24'd1 << n), 4'b0010, 0, 0, "R8 code-bit error");

    // R9: double errors
    for (int n = 0; n < 23; n++)
      rd_check(3, -1, 0, calc(3) ^ (24'd3 << n), 4'b0001, 0, 0, "R9 double in code");
    rd_check(512, -1, 0, calc(512) ^ loc_syn(3, 1) ^ loc_syn(3, 5), 4'b0001, 0, 0, "R9 two bits same byte");
    rd_check(512, -1, 0, calc(512) ^ loc_syn(10, 2) ^ loc_syn(200, 2), 4'b0001, 0, 0, "R9 two bytes");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule